// File: doc/BRIEF.md
# In-Band Xon/Xoff Flow Controller

This block provides software flow control for a byte-oriented serial link. Each byte delivered by the receiver is compared with four programmable character registers: two "stop" characters and two "go" characters. When the stop character (or the stop pair) arrives, the block asks the transmit shifter to pause. When the go character (or the go pair) arrives, transmission resumes. Bytes used up by a match are kept out of the receive path; every other byte is passed on one cycle later.

A small mode register turns flow control on, selects single-character or two-character matching, and enables a special-character detector. The detector raises an interrupt when the second stop character is seen, and still passes that byte on. The configuration registers can be written only while a key value is present on the line-control input. The transmit enable changes only when the shifter reports that it sits between characters, so a character already on the wire always completes.

Top module: `swfc_ctrl`

## Requirements
- R1: After reset `tx_en` is 1, `flow_irq` is 0, `rx_fwd_valid` is 0, and all four character registers hold 0x00.
- R2: A configuration write takes effect only when `lcr_q` equals 0xBF. Otherwise it is ignored. Addresses: 0 = mode, 1 = go char 1, 2 = go char 2, 3 = stop char 1, 4 = stop char 2. Mode bits: bit0 = flow enable, bit1 = dual-character matching, bit2 = special detect.
- R3: With flow enabled in single mode, a received byte equal to stop char 1 suspends transmission and sets `flow_irq`, and the byte is not forwarded.
- R4: With flow enabled in single mode, a received byte equal to go char 1 resumes transmission and clears the stop part of `flow_irq`, and the byte is not forwarded.
- R5: In dual mode, stop char 1 followed directly by stop char 2 suspends, and go char 1 followed directly by go char 2 resumes. Only the second byte of a pair is consumed. Any other byte in between restarts the match.
- R6: With special detect on, a byte equal to stop char 2 that is not consumed is forwarded and sets `flow_irq`. A pulse on `irq_ack` clears both interrupt sources.
- R7: `tx_en` changes only at a clock edge where `tx_idle` is 1. It then takes the inverse of the suspend state.
- R8: A byte that is not consumed appears unchanged on `rx_fwd_byte`, with `rx_fwd_valid` high, one cycle after it is received.
- R9: With flow enable cleared, no byte is consumed and the suspend state is released.
- R10: A byte that matches both a stop and a go condition is treated as a stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lcr_q | input | 8 | Line-control value; 0xBF unlocks configuration writes |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration register select |
| cfg_wdata | input | 8 | Configuration write data |
| rx_valid | input | 1 | Received-byte strobe |
| rx_byte | input | 8 | Received byte |
| tx_idle | input | 1 | Transmit shifter is between characters |
| irq_ack | input | 1 | Clears the interrupt sources |
| rx_fwd_valid | output | 1 | Forwarded byte valid, toward the receive FIFO |
| rx_fwd_byte | output | 8 | Forwarded byte |
| tx_en | output | 1 | Transmit permission to the shifter |
| flow_irq | output | 1 | Stop-character or special-character interrupt |

## Verification
A byte that is strobed in before edge k shows its results after edge k: `rx_fwd_valid`, `rx_fwd_byte` and `flow_irq` all change there. The suspend state also changes at edge k, so `tx_en` follows one edge later, at edge k+1, provided `tx_idle` is high. The bench drives inputs on falling edges. It reads the forwarding and interrupt outputs at the first falling edge after the byte, and reads `tx_en` at the next one. A configuration write needs two more edges before its effect on `tx_en` can be seen, and the bench waits for them. The bench sweeps all 256 byte values in single mode, and all 256 second bytes in dual mode, against an arithmetic model of the matching rules.

// File: rtl/swfc_pkg.sv
package swfc_pkg;
  typedef enum logic [2:0] {
    A_MODE = 3'd0,
    A_GO1  = 3'd1,
    A_GO2  = 3'd2,
    A_STP1 = 3'd3,
    A_STP2 = 3'd4
  } cfg_addr_e;

  typedef struct packed {
    logic spec_en;
    logic dual;
    logic flow_en;
  } mode_t;

  localparam int unsigned MODE_W  = $bits(mode_t);
  localparam int unsigned NUM_CHR = 4;
endpackage

// File: rtl/swfc_regs.sv
module swfc_regs
  import swfc_pkg::*;
#(
  parameter int unsigned W   = 8,
  parameter logic [W-1:0] KEY = 8'hBF
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lcr_q,
  input  logic         cfg_we,
  input  logic [2:0]   cfg_addr,
  input  logic [W-1:0] cfg_wdata,
  output mode_t        mode,
  output logic [W-1:0] go1,
  output logic [W-1:0] go2,
  output logic [W-1:0] stp1,
  output logic [W-1:0] stp2
);
  logic         wr_ok;
  mode_t        mode_q, mode_d;
  logic [W-1:0] chr_q [NUM_CHR];
  logic [W-1:0] chr_d [NUM_CHR];
  logic         unused_hi;

  assign wr_ok     = cfg_we && (lcr_q == KEY);
  assign unused_hi = ^cfg_wdata[W-1:MODE_W];

  always_comb begin
    mode_d = mode_q;
    if (wr_ok && cfg_addr == A_MODE) mode_d = mode_t'(cfg_wdata[MODE_W-1:0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= '0;
    else        mode_q <= mode_d;
  end

  for (genvar i = 0; i < NUM_CHR; i++) begin : g_chr
    always_comb begin
      chr_d[i] = chr_q[i];
      if (wr_ok && cfg_addr == 3'(i + 1)) chr_d[i] = cfg_wdata;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chr_q[i] <= '0;
      else        chr_q[i] <= chr_d[i];
    end
    // R2: locked writes leave the character registers alone
    p_locked_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && lcr_q != KEY) |=> $stable(chr_q[i]));
  end

  assign mode = mode_q;
  assign go1  = chr_q[0];
  assign go2  = chr_q[1];
  assign stp1 = chr_q[2];
  assign stp2 = chr_q[3];
endmodule

// File: rtl/swfc_match.sv
module swfc_match
  import swfc_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         rx_valid,
  input  logic [W-1:0] rx_byte,
  input  mode_t        mode,
  input  logic [W-1:0] go1,
  input  logic [W-1:0] go2,
  input  logic [W-1:0] stp1,
  input  logic [W-1:0] stp2,
  output logic         stop_hit,
  output logic         go_hit,
  output logic         spec_hit,
  output logic         consume
);
  logic pend_stp_q, pend_stp_d;
  logic pend_go_q,  pend_go_d;
  logic stop_raw, go_raw;
  logic single_m, dual_m;

  assign single_m = mode.flow_en && !mode.dual;
  assign dual_m   = mode.flow_en && mode.dual;

  always_comb begin
    stop_raw = 1'b0;
    go_raw   = 1'b0;
    if (rx_valid && single_m) begin
      stop_raw = (rx_byte == stp1);
      go_raw   = (rx_byte == go1);
    end else if (rx_valid && dual_m) begin
      stop_raw = pend_stp_q && (rx_byte == stp2);
      go_raw   = pend_go_q  && (rx_byte == go2);
    end
  end

  assign stop_hit = stop_raw;
  assign go_hit   = go_raw && !stop_raw;
  assign consume  = stop_raw || go_raw;
  assign spec_hit = rx_valid && mode.spec_en && (rx_byte == stp2) && !consume;

  always_comb begin
    pend_stp_d = pend_stp_q;
    pend_go_d  = pend_go_q;
    if (rx_valid) begin
      pend_stp_d = dual_m && (rx_byte == stp1);
      pend_go_d  = dual_m && (rx_byte == go1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_stp_q <= 1'b0;
      pend_go_q  <= 1'b0;
    end else begin
      pend_stp_q <= pend_stp_d;
      pend_go_q  <= pend_go_d;
    end
  end

  // R5: a byte in single mode leaves no half-matched pair behind
  p_single_nopend_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !mode.dual) |=> (!pend_stp_q && !pend_go_q));
  // R9: disabled flow control consumes nothing
  p_off_noconsume_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !mode.flow_en |-> !consume);
endmodule

// File: rtl/swfc_gate.sv
module swfc_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic flow_en,
  input  logic stop_hit,
  input  logic go_hit,
  input  logic spec_hit,
  input  logic irq_ack,
  input  logic tx_idle,
  output logic tx_en,
  output logic flow_irq
);
  logic halt_q, halt_d;
  logic stpf_q, stpf_d;
  logic spcf_q, spcf_d;
  logic txen_q, txen_d;

  always_comb begin
    halt_d = halt_q;
    if (!flow_en)      halt_d = 1'b0;
    else if (stop_hit) halt_d = 1'b1;
    else if (go_hit)   halt_d = 1'b0;

    stpf_d = stpf_q;
    if (stop_hit)               stpf_d = 1'b1;
    else if (go_hit || irq_ack) stpf_d = 1'b0;

    spcf_d = spcf_q;
    if (spec_hit)     spcf_d = 1'b1;
    else if (irq_ack) spcf_d = 1'b0;

    txen_d = txen_q;
    if (tx_idle) txen_d = !halt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      halt_q <= 1'b0;
      stpf_q <= 1'b0;
      spcf_q <= 1'b0;
      txen_q <= 1'b1;
    end else begin
      halt_q <= halt_d;
      stpf_q <= stpf_d;
      spcf_q <= spcf_d;
      txen_q <= txen_d;
    end
  end

  assign tx_en    = txen_q;
  assign flow_irq = stpf_q || spcf_q;

  // R7: mid-character the permission does not move
  p_busy_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_idle |=> $stable(tx_en));
  // R3: a stop match enters the suspend state
  p_stop_halts_r3: assert property (@(posedge clk) disable iff (!rst_n)
    stop_hit |=> (halt_q && flow_irq));
  // R4: a go match leaves it and drops the stop flag
  p_go_resumes_r4: assert property (@(posedge clk) disable iff (!rst_n)
    go_hit |=> (!halt_q && !stpf_q));
  // R9: disabling releases the suspend state
  p_off_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !flow_en |=> !halt_q);
endmodule

// File: rtl/swfc_ctrl.sv
module swfc_ctrl
  import swfc_pkg::*;
#(
  parameter int unsigned W   = 8,
  parameter logic [W-1:0] KEY = 8'hBF
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lcr_q,
  input  logic         cfg_we,
  input  logic [2:0]   cfg_addr,
  input  logic [W-1:0] cfg_wdata,
  input  logic         rx_valid,
  input  logic [W-1:0] rx_byte,
  input  logic         tx_idle,
  input  logic         irq_ack,
  output logic         rx_fwd_valid,
  output logic [W-1:0] rx_fwd_byte,
  output logic         tx_en,
  output logic         flow_irq
);
  mode_t        mode;
  logic [W-1:0] go1, go2, stp1, stp2;
  logic         stop_hit, go_hit, spec_hit, consume;
  logic         fv_q, fv_d;
  logic [W-1:0] fb_q, fb_d;

  swfc_regs #(.W(W), .KEY(KEY)) u_regs (
    .clk(clk), .rst_n(rst_n), .lcr_q(lcr_q), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .mode(mode),
    .go1(go1), .go2(go2), .stp1(stp1), .stp2(stp2)
  );

  swfc_match #(.W(W)) u_match (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .mode(mode), .go1(go1), .go2(go2), .stp1(stp1), .stp2(stp2),
    .stop_hit(stop_hit), .go_hit(go_hit), .spec_hit(spec_hit), .consume(consume)
  );

  swfc_gate u_gate (
    .clk(clk), .rst_n(rst_n), .flow_en(mode.flow_en), .stop_hit(stop_hit),
    .go_hit(go_hit), .spec_hit(spec_hit), .irq_ack(irq_ack), .tx_idle(tx_idle),
    .tx_en(tx_en), .flow_irq(flow_irq)
  );

  always_comb begin
    fv_d = rx_valid && !consume;
    fb_d = fb_q;
    if (fv_d) fb_d = rx_byte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fv_q <= 1'b0;
      fb_q <= '0;
    end else begin
      fv_q <= fv_d;
      fb_q <= fb_d;
    end
  end

  assign rx_fwd_valid = fv_q;
  assign rx_fwd_byte  = fb_q;

  // R3: consumed flow characters never reach the receive path
  p_consumed_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && consume) |=> !rx_fwd_valid);
  // R8: other bytes pass through one cycle later, unchanged
  p_fwd_copy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !consume) |=> (rx_fwd_valid && rx_fwd_byte == $past(rx_byte)));
endmodule

// File: tb/swfc_ctrl_tb.sv
module swfc_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] lcr_q = 8'h00;
  logic       cfg_we = 1'b0;
  logic [2:0] cfg_addr = 3'd0;
  logic [7:0] cfg_wdata = 8'h00;
  logic       rx_valid = 1'b0;
  logic [7:0] rx_byte = 8'h00;
  logic       tx_idle = 1'b1;
  logic       irq_ack = 1'b0;
  logic       rx_fwd_valid, tx_en, flow_irq;
  logic [7:0] rx_fwd_byte;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // model state
  bit m_flow, m_dual, m_spec, m_halt, m_pstp, m_pgo, m_stpf, m_spcf, m_txen;
  logic [7:0] m_go1, m_go2, m_stp1, m_stp2;

  swfc_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .lcr_q(lcr_q), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .rx_valid(rx_valid), .rx_byte(rx_byte), .tx_idle(tx_idle),
    .irq_ack(irq_ack), .rx_fwd_valid(rx_fwd_valid), .rx_fwd_byte(rx_fwd_byte),
    .tx_en(tx_en), .flow_irq(flow_irq)
  );

  always #10 clk = ~clk;

  task automatic check(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d, input logic [7:0] key);
    @(negedge clk);
    lcr_q = key; cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    if (key == 8'hBF) begin
      case (a)
        3'd0: begin m_flow = d[0]; m_dual = d[1]; m_spec = d[2]; end
        3'd1: m_go1 = d;
        3'd2: m_go2 = d;
        3'd3: m_stp1 = d;
        3'd4: m_stp2 = d;
        default: ;
      endcase
    end
    if (!m_flow) m_halt = 1'b0;
    @(negedge clk);
    @(negedge clk);
    if (tx_idle) m_txen = !m_halt;
  endtask

  task automatic send(input logic [7:0] b, input string tag);
    bit sr, gr, cons, sp;
    sr = 1'b0; gr = 1'b0;
    if (m_flow && !m_dual) begin sr = (b == m_stp1); gr = (b == m_go1); end
    else if (m_flow && m_dual) begin sr = m_pstp && (b == m_stp2); gr = m_pgo && (b == m_go2); end
    cons = sr || gr;
    sp = m_spec && (b == m_stp2) && !cons;
    m_pstp = m_flow && m_dual && (b == m_stp1);
    m_pgo  = m_flow && m_dual && (b == m_go1);
    if (sr) begin m_halt = 1'b1; m_stpf = 1'b1; end
    else if (gr) begin m_halt = 1'b0; m_stpf = 1'b0; end
    if (sp) m_spcf = 1'b1;
    @(negedge clk);
    rx_valid = 1'b1; rx_byte = b;
    @(negedge clk);
    rx_valid = 1'b0;
    check({tag, " fwd_valid"}, int'(rx_fwd_valid), int'(!cons));
    if (!cons) check({tag, " fwd_byte"}, int'(rx_fwd_byte), int'(b));
    check({tag, " flow_irq"}, int'(flow_irq), int'(m_stpf || m_spcf));
    @(negedge clk);
    if (tx_idle) m_txen = !m_halt;
    check({tag, " tx_en"}, int'(tx_en), int'(m_txen));
  endtask

  task automatic ack(input string tag);
    @(negedge clk);
    irq_ack = 1'b1;
    @(negedge clk);
    irq_ack = 1'b0;
    m_stpf = 1'b0; m_spcf = 1'b0;
    check({tag, " ack flow_irq"}, int'(flow_irq), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    m_flow = 0; m_dual = 0; m_spec = 0; m_halt = 0; m_pstp = 0; m_pgo = 0;
    m_stpf = 0; m_spcf = 0; m_txen = 1;
    m_go1 = 0; m_go2 = 0; m_stp1 = 0; m_stp2 = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check("R1 reset tx_en", int'(tx_en), 1);
    check("R1 reset flow_irq", int'(flow_irq), 0);
    check("R1 reset fwd_valid", int'(rx_fwd_valid), 0);
    // R1 + R10: characters reset to 0x00, so 0x00 matches go and stop; stop wins
    wr(3'd0, 8'h01, 8'hBF);
    send(8'h00, "R1_R10 zero chars");
    check("R10 halted", int'(tx_en), 0);
    // R9: disabling releases suspension and forwards everything
    wr(3'd0, 8'h00, 8'hBF);
    check("R9 released tx_en", int'(tx_en), 1);
    send(8'h00, "R9 disabled");
    ack("R6");
    // R2: locked writes ignored
    wr(3'd0, 8'h01, 8'hBF);
    wr(3'd1, 8'h11, 8'hBF);
    wr(3'd3, 8'h13, 8'h03);
    send(8'h13, "R2 locked write");
    check("R2 no halt", int'(tx_en), 1);
    wr(3'd3, 8'h13, 8'hBF);
    // R3 R4 R8: single-mode sweep over every byte value
    for (int i = 0; i < 256; i++) begin
      send(8'(i), "R3_R4_R8 sweep");
      if (m_halt) send(8'h11, "R4 resume");
    end
    // R10: identical go and stop characters
    wr(3'd1, 8'h22, 8'hBF);
    wr(3'd3, 8'h22, 8'hBF);
    send(8'h22, "R10 overlap");
    check("R10 stop wins", int'(tx_en), 0);
    wr(3'd0, 8'h00, 8'hBF);
    ack("R6");
    // R5: dual mode
    wr(3'd1, 8'h11, 8'hBF);
    wr(3'd2, 8'h91, 8'hBF);
    wr(3'd3, 8'h13, 8'hBF);
    wr(3'd4, 8'h93, 8'hBF);
    wr(3'd0, 8'h03, 8'hBF);
    send(8'h13, "R5 first stop");
    check("R5 not yet halted", int'(tx_en), 1);
    send(8'h93, "R5 second stop");
    check("R5 halted", int'(tx_en), 0);
    send(8'h11, "R5 first go");
    send(8'h91, "R5 second go");
    check("R5 resumed", int'(tx_en), 1);
    send(8'h13, "R5 restart a");
    send(8'h55, "R5 restart b");
    send(8'h93, "R5 restart c");
    check("R5 broken pair no halt", int'(tx_en), 1);
    for (int i = 0; i < 256; i++) begin
      send(8'h13, "R5 sweep lead");
      send(8'(i), "R5 sweep second");
      if (m_halt) begin
        send(8'h11, "R5 sweep go1");
        send(8'h91, "R5 sweep go2");
      end
    end
    ack("R6");
    // R6: special character detect in single mode
    wr(3'd0, 8'h05, 8'hBF);
    send(8'h93, "R6 special");
    check("R6 flag set", int'(flow_irq), 1);
    check("R6 no halt", int'(tx_en), 1);
    ack("R6");
    // R7: suspension waits for character boundary
    tx_idle = 1'b0;
    send(8'h13, "R7 busy stop");
    repeat (3) begin
      @(negedge clk);
      check("R7 hold while busy", int'(tx_en), 1);
    end
    tx_idle = 1'b1;
    @(negedge clk);
    m_txen = 1'b0;
    check("R7 halt at boundary", int'(tx_en), 0);
    send(8'h11, "R7 resume");
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule